// File: doc/BRIEF.md
# Accumulator Processor Control Sequencer

This block is the control unit of a small accumulator machine with 16-bit words, a 14-bit operand address and a 2-bit opcode. It steps a Mealy state machine through a fetch start state, a three-state instruction fetch, a one-state opcode decode and one of four execute sequences: load, store, add and branch-if-negative. Each cycle it raises the microoperation enables that the surrounding datapath needs, such as PC onto the address bus, address bus into the address register, PC increment and clear, ALU add or pass-B, and the register loads. It also drives the memory request and read/write lines. The datapath registers, the ALU and the memory all sit outside the block.

Memory traffic follows a four-phase exchange on a single wait line. The memory raises wait when it can take a request. The sequencer then asserts request and holds it. The memory drops wait once read data is valid or write data has been taken. The sequencer then drops request, and the memory raises wait again. The wait line and the external reset request both come in through multi-flop synchronizers. An execute sequence never waits for memory to become ready. It hands control straight back to the fetch start, and the next fetch does the readiness check.

Top module: `acc_ctrl_seq`

## Requirements
- R1: While the synchronized reset request is high, the next state is the fetch start state. `uop_pc_clr` is high, `mem_req` is low, and no PC increment or fetch takes place for as long as the request stays high.
- R2: When the sequencer leaves the fetch start state with reset low, `uop_pc_to_abus`, `uop_abus_to_mar` and `uop_pc_inc` are high in the same cycle. The address register therefore gets the old PC, and successive instructions are fetched from consecutive addresses.
- R3: A fetch request is raised only when synchronized wait is high, together with `mem_rd` and `uop_mar_to_maddr`. `mem_req` never rises while the memory holds wait low.
- R4: Once raised, `mem_req` stays high while synchronized wait stays high. In the cycle in which wait is seen low, `uop_mdata_to_mbr` is high and `mem_req` is low.
- R5: After a read, the sequencer waits until wait is high again. It then asserts `uop_mbr_to_ir`, and the next state is decode.
- R6: Decode uses the instruction's two top bits: 00 is load, 01 is store, 10 is add and 11 is branch-if-negative. For load, store and add it moves the 14-bit address field through the address bus into the address register.
- R7: Load reads the operand and writes it to the accumulator with `uop_alu_passb` and `uop_res_to_ac`.
- R8: Add reads the operand and writes accumulator plus operand to the accumulator with `uop_alu_add` and `uop_res_to_ac`.
- R9: Store copies the accumulator into the buffer register on leaving decode. It then runs a write: `mem_req` high, `mem_rd` low, and `uop_mbr_to_mdata` high until wait is seen low.
- R10: Branch-if-negative loads the address field into the PC (`uop_ir_to_abus` with `uop_pc_ld`) only when `ac_msb` is 1. Otherwise the already incremented PC is kept.
- R11: Every execute sequence returns to the fetch start state. Starting a load, store or add access, and leaving its last state, take no wait condition.
- R12: A rising reset request reaches `uop_pc_clr` after exactly SYNC_STAGES rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sys_rst | input | 1 | Asynchronous reset request, synchronized inside |
| mem_wait | input | 1 | Memory wait/ready line, synchronized inside |
| ir_op | input | 2 | Opcode bits of the instruction register |
| ac_msb | input | 1 | Sign bit of the accumulator |
| mem_req | output | 1 | Memory request |
| mem_rd | output | 1 | 1 for read, 0 for write |
| uop_pc_clr | output | 1 | Clear PC |
| uop_pc_inc | output | 1 | Increment PC |
| uop_pc_ld | output | 1 | Load PC from address bus |
| uop_pc_to_abus | output | 1 | Drive PC onto address bus |
| uop_ir_to_abus | output | 1 | Drive instruction address field onto address bus |
| uop_abus_to_mar | output | 1 | Load address register from address bus |
| uop_mar_to_maddr | output | 1 | Drive address register onto memory address bus |
| uop_mdata_to_mbr | output | 1 | Load buffer register from memory data bus |
| uop_mbr_to_mdata | output | 1 | Drive buffer register onto memory data bus |
| uop_mbr_to_ir | output | 1 | Load instruction register from buffer register |
| uop_ac_to_mbr | output | 1 | Load buffer register from accumulator |
| uop_alu_add | output | 1 | ALU adds accumulator and buffer register |
| uop_alu_passb | output | 1 | ALU passes buffer register through |
| uop_res_to_ac | output | 1 | Load accumulator from ALU result |

## Verification
The bench builds the sequencer with SYNC_STAGES = 3. At that depth the reset latency cannot be mistaken for the two-flop default, and each handshake phase spans several cycles. Around the block the bench models the datapath registers and a memory whose ready and recovery delays are swept from 0 to 2 cycles. Over that space it runs a program that exercises every opcode for operand pairs at the sign and overflow boundaries, so that the branch goes both ways. It also injects a reset request at each of 60 successive cycles of a running program, which reaches every state and handshake phase, and then checks that the program runs cleanly again.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  typedef enum logic [3:0] {
    S_RES, S_IF0, S_IF1, S_IF2, S_OD,
    S_LD0, S_LD1, S_LD2,
    S_ST0, S_ST1,
    S_AD0, S_AD1, S_AD2,
    S_BR0
  } seq_state_e;

  localparam int OPC_W = 2;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 2'b00;
  localparam logic [OPC_W-1:0] OPC_STORE = 2'b01;
  localparam logic [OPC_W-1:0] OPC_ADD   = 2'b10;
  localparam logic [OPC_W-1:0] OPC_BNEG  = 2'b11;

  typedef struct packed {
    logic pc_clr;
    logic pc_inc;
    logic pc_ld;
    logic pc_to_abus;
    logic ir_to_abus;
    logic abus_to_mar;
    logic mar_to_maddr;
    logic mdata_to_mbr;
    logic mbr_to_mdata;
    logic mbr_to_ir;
    logic ac_to_mbr;
    logic alu_add;
    logic alu_passb;
    logic res_to_ac;
    logic mem_rd;
    logic mem_req;
  } uop_t;

  localparam uop_t UOP_NONE = '0;

endpackage

// File: rtl/acc_seq_sync.sv
module acc_seq_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/acc_seq_next.sv
module acc_seq_next
  import acc_seq_pkg::*;
(
  input  seq_state_e       state,
  input  logic             reset_s,
  input  logic             wait_s,
  input  logic [OPC_W-1:0] opcode,
  output seq_state_e       nxt
);
  always_comb begin
    nxt = state;
    if (reset_s) begin
      nxt = S_RES;
    end else begin
      case (state)
        S_RES: nxt = S_IF0;
        S_IF0: nxt = wait_s ? S_IF1 : S_IF0;
        S_IF1: nxt = wait_s ? S_IF1 : S_IF2;
        S_IF2: nxt = wait_s ? S_OD  : S_IF2;
        S_OD: begin
          case (opcode)
            OPC_LOAD:  nxt = S_LD0;
            OPC_STORE: nxt = S_ST0;
            OPC_ADD:   nxt = S_AD0;
            default:   nxt = S_BR0;
          endcase
        end
        S_LD0: nxt = S_LD1;
        S_LD1: nxt = wait_s ? S_LD1 : S_LD2;
        S_LD2: nxt = S_RES;
        S_ST0: nxt = S_ST1;
        S_ST1: nxt = wait_s ? S_ST1 : S_RES;
        S_AD0: nxt = S_AD1;
        S_AD1: nxt = wait_s ? S_AD1 : S_AD2;
        S_AD2: nxt = S_RES;
        S_BR0: nxt = S_RES;
        default: nxt = S_RES;
      endcase
    end
  end
endmodule

// File: rtl/acc_seq_uops.sv
module acc_seq_uops
  import acc_seq_pkg::*;
(
  input  seq_state_e       state,
  input  logic             reset_s,
  input  logic             wait_s,
  input  logic [OPC_W-1:0] opcode,
  input  logic             acc_sign,
  output uop_t             uop
);
  always_comb begin
    uop = UOP_NONE;
    if (reset_s) begin
      uop.pc_clr = 1'b1;
    end else begin
      case (state)
        S_RES: begin
          uop.pc_inc      = 1'b1;
          uop.pc_to_abus  = 1'b1;
          uop.abus_to_mar = 1'b1;
        end
        S_IF0: begin
          if (wait_s) begin
            uop.mar_to_maddr = 1'b1;
            uop.mem_rd       = 1'b1;
            uop.mem_req      = 1'b1;
          end
        end
        S_LD0, S_AD0: begin
          uop.mar_to_maddr = 1'b1;
          uop.mem_rd       = 1'b1;
          uop.mem_req      = 1'b1;
        end
        S_IF1, S_LD1, S_AD1: begin
          uop.mar_to_maddr = 1'b1;
          uop.mem_rd       = 1'b1;
          if (wait_s) uop.mem_req      = 1'b1;
          else        uop.mdata_to_mbr = 1'b1;
        end
        S_IF2: begin
          if (wait_s) uop.mbr_to_ir = 1'b1;
        end
        S_OD: begin
          if (opcode != OPC_BNEG) begin
            uop.ir_to_abus  = 1'b1;
            uop.abus_to_mar = 1'b1;
          end
          if (opcode == OPC_STORE) uop.ac_to_mbr = 1'b1;
        end
        S_ST0: begin
          uop.mar_to_maddr = 1'b1;
          uop.mbr_to_mdata = 1'b1;
          uop.mem_req      = 1'b1;
        end
        S_ST1: begin
          uop.mar_to_maddr = 1'b1;
          uop.mbr_to_mdata = 1'b1;
          uop.mem_req      = wait_s;
        end
        S_LD2: begin
          uop.alu_passb = 1'b1;
          uop.res_to_ac = 1'b1;
        end
        S_AD2: begin
          uop.alu_add   = 1'b1;
          uop.res_to_ac = 1'b1;
        end
        S_BR0: begin
          if (acc_sign) begin
            uop.ir_to_abus = 1'b1;
            uop.pc_ld      = 1'b1;
          end
        end
        default: uop = UOP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/acc_ctrl_seq.sv
module acc_ctrl_seq
  import acc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst,
  input  logic       mem_wait,
  input  logic [1:0] ir_op,
  input  logic       ac_msb,
  output logic       mem_req,
  output logic       mem_rd,
  output logic       uop_pc_clr,
  output logic       uop_pc_inc,
  output logic       uop_pc_ld,
  output logic       uop_pc_to_abus,
  output logic       uop_ir_to_abus,
  output logic       uop_abus_to_mar,
  output logic       uop_mar_to_maddr,
  output logic       uop_mdata_to_mbr,
  output logic       uop_mbr_to_mdata,
  output logic       uop_mbr_to_ir,
  output logic       uop_ac_to_mbr,
  output logic       uop_alu_add,
  output logic       uop_alu_passb,
  output logic       uop_res_to_ac
);
  logic       reset_s;
  logic       wait_s;
  seq_state_e state;
  seq_state_e state_nxt;
  uop_t       u;

  // Reset request synchronizer: comes out of reset asserted
  acc_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_rst (
    .clk(clk), .rst_n(rst_n), .d(sys_rst), .q(reset_s)
  );

  acc_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_wait (
    .clk(clk), .rst_n(rst_n), .d(mem_wait), .q(wait_s)
  );

  acc_seq_next i_next (
    .state(state), .reset_s(reset_s), .wait_s(wait_s),
    .opcode(ir_op), .nxt(state_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_RES;
    else        state <= state_nxt;
  end

  acc_seq_uops i_uops (
    .state(state), .reset_s(reset_s), .wait_s(wait_s),
    .opcode(ir_op), .acc_sign(ac_msb), .uop(u)
  );

  assign mem_req          = u.mem_req;
  assign mem_rd           = u.mem_rd;
  assign uop_pc_clr       = u.pc_clr;
  assign uop_pc_inc       = u.pc_inc;
  assign uop_pc_ld        = u.pc_ld;
  assign uop_pc_to_abus   = u.pc_to_abus;
  assign uop_ir_to_abus   = u.ir_to_abus;
  assign uop_abus_to_mar  = u.abus_to_mar;
  assign uop_mar_to_maddr = u.mar_to_maddr;
  assign uop_mdata_to_mbr = u.mdata_to_mbr;
  assign uop_mbr_to_mdata = u.mbr_to_mdata;
  assign uop_mbr_to_ir    = u.mbr_to_ir;
  assign uop_ac_to_mbr    = u.ac_to_mbr;
  assign uop_alu_add      = u.alu_add;
  assign uop_alu_passb    = u.alu_passb;
  assign uop_res_to_ac    = u.res_to_ac;

  // R1: reset forces the fetch start state and keeps memory quiet
  p_reset_to_res_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reset_s |=> (state == S_RES));
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reset_s |-> (u.pc_clr && !u.mem_req && !u.pc_inc && !u.pc_to_abus));

  // R2: leaving the start state copies the old PC and bumps the PC together
  p_fetch_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RES && !reset_s) |-> (u.pc_inc && u.pc_to_abus && u.abus_to_mar));

  // R3: a request only rises while memory signals ready
  p_req_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(u.mem_req) |-> wait_s);

  // R4: request is held until wait drops, data captured with request low
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (u.mem_req && !reset_s) |=> (u.mem_req || !wait_s || reset_s));
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    u.mdata_to_mbr |-> (!wait_s && !u.mem_req && u.mem_rd));

  // R5: instruction register load leads into decode
  p_to_decode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    u.mbr_to_ir |=> (state == S_OD));

  // R6: at most one source on the address bus
  p_abus_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({u.pc_to_abus, u.ir_to_abus}));

  // R9: a store cycle is a write
  p_store_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (u.mem_req && u.mbr_to_mdata) |-> !u.mem_rd);

  // R10: the PC is only overwritten by a taken branch
  p_branch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    u.pc_ld |-> (ac_msb && state == S_BR0));

  // R11: execute sequences neither stall at their start nor at their end
  p_no_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_s && state inside {S_LD0, S_ST0, S_AD0})
      |=> (state inside {S_LD1, S_ST1, S_AD1}));
  p_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_s && state inside {S_LD2, S_AD2, S_BR0}) |=> (state == S_RES));

endmodule

// File: tb/test_acc_ctrl_seq.sv
module test_acc_ctrl_seq;
  localparam int SYNC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_rst = 1'b1;
  logic mem_wait = 1'b1;

  logic mem_req, mem_rd, uop_pc_clr, uop_pc_inc, uop_pc_ld, uop_pc_to_abus;
  logic uop_ir_to_abus, uop_abus_to_mar, uop_mar_to_maddr, uop_mdata_to_mbr;
  logic uop_mbr_to_mdata, uop_mbr_to_ir, uop_ac_to_mbr, uop_alu_add;
  logic uop_alu_passb, uop_res_to_ac;

  // Datapath and memory model
  logic [13:0] pc_r = '0;
  logic [13:0] mar_r = '0;
  logic [15:0] mbr_r = '0;
  logic [15:0] ir_r = '0;
  logic [15:0] ac_r = '0;
  logic [15:0] mem [0:63];

  typedef enum int {M_RDY, M_BSY, M_DON, M_REC} mst_e;
  mst_e mst = M_RDY;
  int   dly_a = 0;
  int   dly_b = 0;
  int   cnt = 0;
  logic m_rd = 1'b0;
  logic req_q = 1'b0;
  logic in_rst = 1'b1;
  int   fetch_cnt = 0;
  logic [13:0] last_fetch = '0;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  acc_ctrl_seq #(.SYNC_STAGES(SYNC)) i_acc_ctrl_seq (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .mem_wait(mem_wait),
    .ir_op(ir_r[15:14]), .ac_msb(ac_r[15]),
    .mem_req(mem_req), .mem_rd(mem_rd),
    .uop_pc_clr(uop_pc_clr), .uop_pc_inc(uop_pc_inc), .uop_pc_ld(uop_pc_ld),
    .uop_pc_to_abus(uop_pc_to_abus), .uop_ir_to_abus(uop_ir_to_abus),
    .uop_abus_to_mar(uop_abus_to_mar), .uop_mar_to_maddr(uop_mar_to_maddr),
    .uop_mdata_to_mbr(uop_mdata_to_mbr), .uop_mbr_to_mdata(uop_mbr_to_mdata),
    .uop_mbr_to_ir(uop_mbr_to_ir), .uop_ac_to_mbr(uop_ac_to_mbr),
    .uop_alu_add(uop_alu_add), .uop_alu_passb(uop_alu_passb),
    .uop_res_to_ac(uop_res_to_ac)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Datapath registers and memory react half a cycle away from the active edge
  always @(negedge clk) begin
    logic [13:0] abus;
    logic [15:0] res;
    abus = uop_pc_to_abus ? pc_r : (uop_ir_to_abus ? ir_r[13:0] : 14'h0);
    res  = uop_alu_add ? (ac_r + mbr_r) : mbr_r;
    if (uop_pc_clr)      pc_r <= '0;
    else if (uop_pc_ld)  pc_r <= abus;
    else if (uop_pc_inc) pc_r <= pc_r + 14'd1;
    if (uop_abus_to_mar) mar_r <= abus;
    if (uop_mdata_to_mbr) begin
      chk(mst == M_DON && !mem_req, "R4 capture", {31'd0, mem_req}, 32'd0);
      mbr_r <= mem[mar_r[5:0]];
    end else if (uop_ac_to_mbr) begin
      mbr_r <= ac_r;
    end
    if (uop_mbr_to_ir) ir_r <= mbr_r;
    if (uop_res_to_ac) ac_r <= res;
    if (uop_pc_to_abus) begin
      fetch_cnt  <= fetch_cnt + 1;
      last_fetch <= pc_r;
    end
    if (mem_req && !req_q)
      chk(mem_wait, "R3 request while busy", {31'd0, mem_wait}, 32'd1);
    req_q <= mem_req;

    case (mst)
      M_RDY: begin
        if (mem_req) begin
          mst  <= M_BSY;
          cnt  <= dly_a;
          m_rd <= mem_rd;
        end
      end
      M_BSY: begin
        if (!mem_req) begin
          if (!in_rst) chk(1'b0, "R4 request dropped early", 32'd0, 32'd1);
          mst <= M_RDY;
        end else if (cnt == 0) begin
          if (!m_rd) begin
            chk(uop_mbr_to_mdata && !mem_rd && uop_mar_to_maddr, "R9 write drive",
                {30'd0, uop_mbr_to_mdata, mem_rd}, 32'd2);
            mem[mar_r[5:0]] <= mbr_r;
          end
          mem_wait <= 1'b0;
          mst      <= M_DON;
        end else begin
          cnt <= cnt - 1;
        end
      end
      M_DON: begin
        if (!mem_req) begin
          mst <= M_REC;
          cnt <= dly_b;
        end
      end
      default: begin
        if (cnt == 0) begin
          mem_wait <= 1'b1;
          mst      <= M_RDY;
        end else begin
          cnt <= cnt - 1;
        end
      end
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_err++;
      $display("FAIL R11 watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  localparam logic [1:0] LD = 2'b00, ST = 2'b01, AD = 2'b10, BN = 2'b11;

  task automatic load_prog(input logic [15:0] a, input logic [15:0] b);
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    mem[0] = {LD, 14'd40};
    mem[1] = {AD, 14'd41};
    mem[2] = {ST, 14'd42};
    mem[3] = {BN, 14'd6};
    mem[4] = {LD, 14'd41};
    mem[5] = {ST, 14'd43};
    mem[6] = {AD, 14'd40};
    mem[7] = {ST, 14'd44};
    mem[40] = a;
    mem[41] = b;
    mem[43] = 16'hDEAD;
  endtask

  task automatic settle();
    in_rst  = 1'b1;
    sys_rst = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
    while (!(mst == M_RDY && mem_wait)) @(negedge clk);
    repeat (SYNC + 1) @(negedge clk);
    #1;
  endtask

  task automatic run_prog(input logic [15:0] a, input logic [15:0] b,
                          input int da, input int db);
    int base;
    logic [15:0] s;
    bit neg;
    load_prog(a, b);
    dly_a = da;
    dly_b = db;
    base  = fetch_cnt;
    sys_rst = 1'b0;
    in_rst  = 1'b0;
    do begin
      @(negedge clk);
      #1;
    end while (!(fetch_cnt > base && last_fetch == 14'd8));
    s   = a + b;
    neg = s[15];
    chk(ac_r == (neg ? s + a : s), "R7 load/add accumulator", ac_r, neg ? s + a : s);
    chk(mem[42] == s, "R8 sum stored", mem[42], s);
    chk(mem[43] == (neg ? 16'hDEAD : b), "R10 branch skip", mem[43],
        neg ? 16'hDEAD : b);
    chk(mem[44] == (neg ? s + a : s), "R9 store", mem[44], neg ? s + a : s);
    chk(fetch_cnt - base == (neg ? 7 : 9), "R6 decode path", fetch_cnt - base,
        neg ? 7 : 9);
    settle();
  endtask

  task automatic reset_mid(input int x);
    int base;
    load_prog(16'h8000, 16'h0001);
    dly_a = x % 3;
    dly_b = (x / 3) % 3;
    sys_rst = 1'b0;
    in_rst  = 1'b0;
    repeat (x) @(negedge clk);
    #1;
    in_rst  = 1'b1;
    sys_rst = 1'b1;
    repeat (SYNC - 1) @(negedge clk);
    #1;
    chk(!uop_pc_clr, "R12 latency early", {31'd0, uop_pc_clr}, 32'd0);
    @(negedge clk);
    #1;
    chk(uop_pc_clr, "R12 latency", {31'd0, uop_pc_clr}, 32'd1);
    base = fetch_cnt;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #1;
      chk(uop_pc_clr && !mem_req && !uop_pc_inc, "R1 held in reset",
          {29'd0, uop_pc_clr, mem_req, uop_pc_inc}, 32'd4);
    end
    chk(fetch_cnt == base, "R1 no fetch", fetch_cnt, base);
    settle();
    run_prog(16'h0005, 16'hFFF0, 1, 0);
  endtask

  initial begin
    logic [15:0] vals [4];
    vals[0] = 16'h0001;
    vals[1] = 16'h7FFF;
    vals[2] = 16'h8000;
    vals[3] = 16'hFFFF;
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    #1;
    chk(uop_pc_clr && !mem_req, "R1 reset state", {30'd0, uop_pc_clr, mem_req}, 32'd2);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #1;
      chk(uop_pc_clr && !mem_req && !uop_pc_to_abus, "R1 stays in reset",
          {29'd0, uop_pc_clr, mem_req, uop_pc_to_abus}, 32'd4);
    end
    chk(fetch_cnt == 0, "R1 no fetch in reset", fetch_cnt, 0);
    settle();

    // R2 R3 R4 R5 R11: handshake monitors fire during every run below
    for (int ia = 0; ia < 4; ia++)
      for (int ib = 0; ib < 4; ib++)
        for (int d = 0; d < 9; d++)
          run_prog(vals[ia], vals[ib], d % 3, d / 3);

    // R1 R12: reset request injected at each cycle of a running program
    for (int x = SYNC + 1; x < SYNC + 61; x++) reset_mid(x);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule